// File: doc/BRIEF.md
# Posted-Write Up-Counting Interval Timer

The block is a timer whose 32-bit counter counts upward on a functional clock. Its register interface runs on a separate interface clock. Software sets a delay of N ticks by writing all-ones minus N into the counter and then setting the start bit. When the count wraps past all-ones, the block raises an overflow status bit. That bit drives an interrupt output and a wakeup output through separate enable bits. With auto-reload set, each wrap copies the load register into the counter and counting goes on. Without auto-reload, the timer halts at zero.

Writes to the control, counter and load registers are posted into the functional domain over toggle handshakes. Each of these registers has its own pending flag that software polls before it rewrites the register. When posted mode is off, the interface holds its ready signal low until the value has landed, and the pending register reads zero. Counter reads return a snapshot that is carried across on a two-flop handshake, so a read never returns a torn value. A self-clearing soft-reset bit returns every register to its default.

The interface is a valid/ready request port. A request is taken in the interface-clock cycle in which `bus_valid` and `bus_ready` are both high. `bus_rdata` is valid in that same cycle. A requester holds its request steady while `bus_ready` is low. Reads and writes to non-posted registers are never held back.

Top module: `pwt_timer`

## Requirements
- R1: While running, the counter adds one on every functional clock. A wrap from all-ones sets the overflow status bit (bit 0 at word address 3). A count written as all-ones minus N overflows N+1 functional clocks after the start bit takes effect.
- R2: If auto-reload (control bit 1) is clear, a wrap leaves the counter at zero and stops the timer. The start bit (control bit 0, word address 0) then reads 0.
- R3: If auto-reload is set, every wrap loads the counter from the load register (word address 2). Overflows then repeat with a period of (all-ones minus load) plus one functional clocks.
- R4: Pending register (word address 7) bit 0 = control, bit 1 = counter, bit 2 = load. Each flag rises on a write to its register and clears once the value has taken effect in the functional domain. In posted mode, a write to a register whose flag is set is stalled.
- R5: When posted mode (interface-control bit 2, word address 6) is 0, a write to control, counter or load keeps `bus_ready` low until the value has crossed, and the pending register reads 0.
- R6: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged. A new overflow takes priority over a clear in the same cycle.
- R7: `irq` is status AND interrupt-enable bit 0 (word address 4). `wake` is status AND wakeup-enable bit 0 (word address 5).
- R8: A counter write (word address 1) sets the count, and a later counter read returns it. A load write does not change the count.
- R9: Once a cleared start bit has taken effect, the counter holds its value.
- R10: Writing 1 to interface-control bit 0 starts a soft reset. The bit reads 1 until the reset is done. After that, all registers, including posted mode and the count, are back at 0.
- R11: After reset, control, counter, load, status, enables, interface control and pending all read 0, and `irq` and `wake` are low.
- R12: The enable registers keep only bit 0. Control keeps bits 1:0. Load reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| iclk | input | 1 | Interface clock |
| fclk | input | 1 | Functional (counting) clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request accepted this cycle when high with valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the accepting cycle |
| irq | output | 1 | Overflow interrupt |
| wake | output | 1 | Overflow wakeup |

## Verification
Timing for each result:
- **Posted write:** the value lands on the third functional edge after acceptance. The pending flag clears two interface edges later.
- **Overflow:** the status bit follows the wrap by two interface edges plus one.
- **Counter read:** the snapshot trails the count by a handshake round trip. The bench waits 20 to 40 interface cycles before reading the count.
- **Interval checks:** the clocks are asynchronous, so these are windows one or two cycles wide around the computed value:
  - one-shot delay: (N+4) functional periods from acceptance to `irq`;
  - auto-reload period: 21 functional periods between rises;
  - non-posted stall: at least five cycles.

Register readbacks that need no crossing are taken in the cycle the request is accepted.

// File: rtl/pwt_pkg.sv
`timescale 1ns/1ps
package pwt_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_COUNT = 3'd1,
    A_LOAD  = 3'd2,
    A_STAT  = 3'd3,
    A_IEN   = 3'd4,
    A_WEN   = 3'd5,
    A_IFC   = 3'd6,
    A_PEND  = 3'd7
  } reg_addr_e;
  localparam int NCH     = 4;
  localparam int CH_CTRL = 0;
  localparam int CH_CNT  = 1;
  localparam int CH_LOAD = 2;
  localparam int CH_SRST = 3;
endpackage

// File: rtl/pwt_xfer_chan.sv
`timescale 1ns/1ps
// One posted write channel: toggle request from iclk, applied in fclk,
// toggle acknowledge back to iclk.
module pwt_xfer_chan #(
  parameter int W    = 32,
  parameter int SYNC = 2
) (
  input  logic         iclk,
  input  logic         fclk,
  input  logic         rst_n,
  input  logic         launch,
  input  logic [W-1:0] launch_data,
  output logic         pend,
  output logic         apply,
  output logic [W-1:0] apply_data
);
  logic            req_tgl;
  logic [W-1:0]    hold;
  logic [SYNC-1:0] ack_s;
  logic [SYNC-1:0] req_s;
  logic            req_d;
  logic            ack_tgl;

  always_ff @(posedge iclk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl <= 1'b0;
      hold    <= '0;
      ack_s   <= '0;
    end else begin
      ack_s <= {ack_s[SYNC-2:0], ack_tgl};
      if (launch) begin
        req_tgl <= ~req_tgl;
        hold    <= launch_data;
      end
    end
  end

  assign pend = req_tgl ^ ack_s[SYNC-1];

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      req_s   <= '0;
      req_d   <= 1'b0;
      ack_tgl <= 1'b0;
    end else begin
      req_s   <= {req_s[SYNC-2:0], req_tgl};
      req_d   <= req_s[SYNC-1];
      ack_tgl <= req_s[SYNC-1];
    end
  end

  assign apply      = req_s[SYNC-1] ^ req_d;
  assign apply_data = hold;

  // R4
  relaunch_chk: assert property (@(posedge iclk) disable iff (!rst_n)
    launch |-> !pend);
  // R4
  pend_src_chk: assert property (@(posedge iclk) disable iff (!rst_n)
    $rose(pend) |-> $past(launch));
endmodule

// File: rtl/pwt_snap.sv
`timescale 1ns/1ps
// Coherent snapshot of a multi-bit fclk value into iclk.
module pwt_snap #(
  parameter int W    = 32,
  parameter int SYNC = 2
) (
  input  logic         fclk,
  input  logic         iclk,
  input  logic         rst_n,
  input  logic [W-1:0] val,
  output logic [W-1:0] q
);
  logic            stgl;
  logic [W-1:0]    snap;
  logic [SYNC-1:0] ack_s;
  logic [SYNC-1:0] tgl_s;
  logic            tgl_d;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      stgl  <= 1'b0;
      snap  <= '0;
      ack_s <= '0;
    end else begin
      ack_s <= {ack_s[SYNC-2:0], tgl_d};
      if (ack_s[SYNC-1] == stgl) begin
        snap <= val;
        stgl <= ~stgl;
      end
    end
  end

  always_ff @(posedge iclk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_s <= '0;
      tgl_d <= 1'b0;
      q     <= '0;
    end else begin
      tgl_s <= {tgl_s[SYNC-2:0], stgl};
      tgl_d <= tgl_s[SYNC-1];
      if (tgl_s[SYNC-1] != tgl_d) q <= snap;
    end
  end
endmodule

// File: rtl/pwt_tgl_rx.sv
`timescale 1ns/1ps
// Turns a toggle from another domain into a one-cycle pulse.
module pwt_tgl_rx #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl,
  output logic pulse
);
  logic [SYNC-1:0] s;
  logic            d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s <= '0;
      d <= 1'b0;
    end else begin
      s <= {s[SYNC-2:0], tgl};
      d <= s[SYNC-1];
    end
  end

  assign pulse = s[SYNC-1] ^ d;
endmodule

// File: rtl/pwt_count_core.sv
`timescale 1ns/1ps
// Functional-domain counter with start, auto-reload and load.
module pwt_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             fclk,
  input  logic             rst_n,
  input  logic             apply_ctrl,
  input  logic [1:0]       ctrl_d,
  input  logic             apply_cnt,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic             apply_load,
  input  logic [CNT_W-1:0] load_d,
  input  logic             apply_srst,
  output logic [CNT_W-1:0] count,
  output logic             ovf_tgl
);
  localparam logic [CNT_W-1:0] ONES = '1;

  logic             start_q;
  logic             ar_q;
  logic [CNT_W-1:0] load_q;
  logic             wrap;
  logic             apply_any;

  assign wrap      = start_q && (count == ONES);
  assign apply_any = apply_ctrl | apply_cnt | apply_load | apply_srst;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      ar_q    <= 1'b0;
      load_q  <= '0;
      count   <= '0;
      ovf_tgl <= 1'b0;
    end else if (apply_srst) begin
      start_q <= 1'b0;
      ar_q    <= 1'b0;
      load_q  <= '0;
      count   <= '0;
    end else begin
      if (apply_ctrl) begin
        start_q <= ctrl_d[0];
        ar_q    <= ctrl_d[1];
      end else if (wrap && !ar_q) begin
        start_q <= 1'b0;
      end
      if (apply_load) load_q <= load_d;
      if (apply_cnt)    count <= cnt_d;
      else if (wrap)    count <= ar_q ? load_q : '0;
      else if (start_q) count <= count + CNT_W'(1);
      if (wrap) ovf_tgl <= ~ovf_tgl;
    end
  end

  // R1
  count_up_chk: assert property (@(posedge fclk) disable iff (!rst_n)
    (start_q && !apply_any && count != ONES) |=> count == $past(count) + CNT_W'(1));
  // R2
  oneshot_stop_chk: assert property (@(posedge fclk) disable iff (!rst_n)
    (start_q && !ar_q && count == ONES && !apply_any) |=> (!start_q && count == '0));
  // R3
  reload_chk: assert property (@(posedge fclk) disable iff (!rst_n)
    (start_q && ar_q && count == ONES && !apply_any) |=> count == $past(load_q));
  // R9
  hold_chk: assert property (@(posedge fclk) disable iff (!rst_n)
    (!start_q && !apply_any) |=> $stable(count));
endmodule

// File: rtl/pwt_timer.sv
`timescale 1ns/1ps
module pwt_timer
  import pwt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SYNC  = 2
) (
  input  logic              iclk,
  input  logic              fclk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              wake
);
  logic [1:0]       ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] cnt_rd;
  logic             stat_q, ien_q, wen_q, posted_q, srst_q, np_wait;
  logic [NCH-1:0]   sel, pend, launch;
  logic             fire, tgt_pend, is_chan, ovf_pulse, srst_done, stat_clr;

  logic             ap_ctrl, ap_cnt, ap_load, ap_srst_raw;
  logic [1:0]       ctrl_f;
  logic [CNT_W-1:0] cnt_f, load_f, count_f;
  logic [0:0]       srst_f;
  logic             ovf_tgl;

  always_comb begin
    sel          = '0;
    sel[CH_CTRL] = (bus_addr == A_CTRL);
    sel[CH_CNT]  = (bus_addr == A_COUNT);
    sel[CH_LOAD] = (bus_addr == A_LOAD);
    sel[CH_SRST] = (bus_addr == A_IFC) && bus_wdata[0];
  end

  assign is_chan  = |sel[CH_LOAD:CH_CTRL];
  assign tgt_pend = |(sel[CH_LOAD:CH_CTRL] & pend[CH_LOAD:CH_CTRL]);

  always_comb begin
    if (!bus_write)        bus_ready = 1'b1;
    else if (is_chan)      bus_ready = !tgt_pend && (posted_q || np_wait);
    else if (sel[CH_SRST]) bus_ready = !pend[CH_SRST];
    else                   bus_ready = 1'b1;
  end

  assign fire = bus_valid && bus_ready;

  always_comb begin
    for (int i = 0; i < CH_SRST; i++)
      launch[i] = bus_valid && bus_write && sel[i] && !pend[i] && (posted_q || !np_wait);
    launch[CH_SRST] = bus_valid && bus_write && sel[CH_SRST] && !pend[CH_SRST];
  end

  assign srst_done = srst_q && !pend[CH_SRST];
  assign stat_clr  = fire && bus_write && (bus_addr == A_STAT) && bus_wdata[0];

  always_ff @(posedge iclk or negedge rst_n) begin
    if (!rst_n) begin
      np_wait <= 1'b0;
    end else if (fire) begin
      np_wait <= 1'b0;
    end else if ((|launch[CH_LOAD:CH_CTRL]) && !posted_q) begin
      np_wait <= 1'b1;
    end
  end

  always_ff @(posedge iclk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      load_q   <= '0;
      stat_q   <= 1'b0;
      ien_q    <= 1'b0;
      wen_q    <= 1'b0;
      posted_q <= 1'b0;
      srst_q   <= 1'b0;
    end else if (srst_done) begin
      ctrl_q   <= '0;
      load_q   <= '0;
      stat_q   <= 1'b0;
      ien_q    <= 1'b0;
      wen_q    <= 1'b0;
      posted_q <= 1'b0;
      srst_q   <= 1'b0;
    end else begin
      if (launch[CH_CTRL])
        ctrl_q <= bus_wdata[1:0];
      else if (ovf_pulse && !ctrl_q[1] && !pend[CH_CTRL])
        ctrl_q[0] <= 1'b0;
      if (launch[CH_LOAD]) load_q <= bus_wdata;
      if (ovf_pulse)     stat_q <= 1'b1;
      else if (stat_clr) stat_q <= 1'b0;
      if (fire && bus_write && bus_addr == A_IEN) ien_q    <= bus_wdata[0];
      if (fire && bus_write && bus_addr == A_WEN) wen_q    <= bus_wdata[0];
      if (fire && bus_write && bus_addr == A_IFC) posted_q <= bus_wdata[2];
      if (launch[CH_SRST]) srst_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[1:0] = ctrl_q;
      A_COUNT: bus_rdata      = cnt_rd;
      A_LOAD:  bus_rdata      = load_q;
      A_STAT:  bus_rdata[0]   = stat_q;
      A_IEN:   bus_rdata[0]   = ien_q;
      A_WEN:   bus_rdata[0]   = wen_q;
      A_IFC:   bus_rdata[2:0] = {posted_q, 1'b0, srst_q};
      default: bus_rdata[2:0] = posted_q ? pend[CH_LOAD:CH_CTRL] : 3'b000;
    endcase
  end

  assign irq  = stat_q & ien_q;
  assign wake = stat_q & wen_q;

  pwt_xfer_chan #(.W(2), .SYNC(SYNC)) u_ch_ctrl (
    .iclk(iclk), .fclk(fclk), .rst_n(rst_n), .launch(launch[CH_CTRL]),
    .launch_data(bus_wdata[1:0]), .pend(pend[CH_CTRL]), .apply(ap_ctrl),
    .apply_data(ctrl_f));

  pwt_xfer_chan #(.W(CNT_W), .SYNC(SYNC)) u_ch_cnt (
    .iclk(iclk), .fclk(fclk), .rst_n(rst_n), .launch(launch[CH_CNT]),
    .launch_data(bus_wdata), .pend(pend[CH_CNT]), .apply(ap_cnt),
    .apply_data(cnt_f));

  pwt_xfer_chan #(.W(CNT_W), .SYNC(SYNC)) u_ch_load (
    .iclk(iclk), .fclk(fclk), .rst_n(rst_n), .launch(launch[CH_LOAD]),
    .launch_data(bus_wdata), .pend(pend[CH_LOAD]), .apply(ap_load),
    .apply_data(load_f));

  pwt_xfer_chan #(.W(1), .SYNC(SYNC)) u_ch_srst (
    .iclk(iclk), .fclk(fclk), .rst_n(rst_n), .launch(launch[CH_SRST]),
    .launch_data(1'b1), .pend(pend[CH_SRST]), .apply(ap_srst_raw),
    .apply_data(srst_f));

  pwt_count_core #(.CNT_W(CNT_W)) u_core (
    .fclk(fclk), .rst_n(rst_n),
    .apply_ctrl(ap_ctrl), .ctrl_d(ctrl_f),
    .apply_cnt(ap_cnt), .cnt_d(cnt_f),
    .apply_load(ap_load), .load_d(load_f),
    .apply_srst(ap_srst_raw & srst_f[0]),
    .count(count_f), .ovf_tgl(ovf_tgl));

  pwt_snap #(.W(CNT_W), .SYNC(SYNC)) u_snap (
    .fclk(fclk), .iclk(iclk), .rst_n(rst_n), .val(count_f), .q(cnt_rd));

  pwt_tgl_rx #(.SYNC(SYNC)) u_ovf_rx (
    .clk(iclk), .rst_n(rst_n), .tgl(ovf_tgl), .pulse(ovf_pulse));

  // R6
  stat_w1c_chk: assert property (@(posedge iclk) disable iff (!rst_n)
    (stat_clr && !ovf_pulse) |=> !irq && !wake);
  // R6
  stat_sticky_chk: assert property (@(posedge iclk) disable iff (!rst_n)
    (stat_q && !stat_clr && !srst_done) |=> stat_q);
  // R5
  np_hold_chk: assert property (@(posedge iclk) disable iff (!rst_n)
    (!posted_q && bus_valid && bus_write && (|launch[CH_LOAD:CH_CTRL])) |-> !bus_ready);
  // R7
  irq_gate_chk: assert property (@(posedge iclk) disable iff (!rst_n)
    $rose(irq) |-> (ien_q && ($past(ovf_pulse) || $rose(ien_q))));
endmodule

// File: tb/pwt_timer_tb.sv
`timescale 1ns/1ps
module pwt_timer_tb;
  import pwt_pkg::*;

  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic        iclk = 1'b0;
  logic        fclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        irq, wake;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2.5 iclk = ~iclk;
  always #6   fclk = ~fclk;
  always @(posedge iclk) cyc <= cyc + 1;

  pwt_timer u_dut (
    .iclk(iclk), .fclk(fclk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wake(wake));

  // addr, write data, expected read-back (R12)
  localparam logic [66:0] VEC [0:7] = '{
    {3'd4, 32'hFFFF_FFFF, 32'h0000_0001},
    {3'd5, 32'h0000_0003, 32'h0000_0001},
    {3'd4, 32'h0000_0000, 32'h0000_0000},
    {3'd5, 32'hFFFF_FFFE, 32'h0000_0000},
    {3'd2, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {3'd2, 32'h0000_0000, 32'h0000_0000},
    {3'd0, 32'hFFFF_FFFE, 32'h0000_0002},
    {3'd0, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic xfer(input logic wr, input logic [2:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output int stall);
    @(negedge iclk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    stall = 0;
    #1;
    while (!bus_ready) begin
      @(negedge iclk); #1;
      stall++;
    end
    rd = bus_rdata;
    @(posedge iclk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    logic [31:0] r; int s;
    xfer(1'b1, a, d, r, s);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    int s;
    xfer(1'b0, a, 32'h0, v, s);
  endtask

  task automatic wait_pend();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(3'd7, v);
      if (v[2:0] == 3'b000) break;
    end
  endtask

  task automatic wait_irq(output int t);
    int n = 0;
    @(posedge iclk); #1;
    while (!irq && n < 2000) begin
      @(posedge iclk); #1;
      n++;
    end
    t = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge iclk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a;
    int s, t0, t1, t2;

    repeat (10) @(posedge iclk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge iclk);

    // R11 reset state
    rd(3'd0, v); check("R11 ctrl", v, 0);
    rd(3'd1, v); check("R11 count", v, 0);
    rd(3'd2, v); check("R11 load", v, 0);
    rd(3'd3, v); check("R11 status", v, 0);
    rd(3'd6, v); check("R11 ifctrl", v, 0);
    rd(3'd7, v); check("R11 pend", v, 0);
    check("R11 irq/wake", {30'b0, irq, wake}, 0);

    wr(3'd6, 32'h4);
    rd(3'd6, v); check("R4 posted on", v, 32'h4);

    // R12 table walk
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][66:64], VEC[i][63:32]);
      rd(VEC[i][66:64], v);
      check("R12 readback", v, VEC[i][31:0]);
    end
    wait_pend();

    // R4 pending flag and stall
    wr(3'd2, 32'h55);
    rd(3'd7, v); check("R4 load pending", v, 32'h4);
    wait_pend();
    rd(3'd7, v); check("R4 pend cleared", v, 0);
    wr(3'd2, 32'h66);
    xfer(1'b1, 3'd2, 32'h67, v, s);
    check_rng("R4 stall while pending", s, 3, 40);
    wait_pend();

    // R8 count write, load no effect
    wr(3'd1, 32'h1234); wait_pend(); repeat (30) @(posedge iclk);
    rd(3'd1, v); check("R8 count write", v, 32'h1234);
    wr(3'd2, 32'hABCD); wait_pend(); repeat (30) @(posedge iclk);
    rd(3'd1, v); check("R8 load no effect", v, 32'h1234);
    rd(3'd2, v); check("R8 load readback", v, 32'hABCD);

    // R1 one-shot delay, R2 stop at overflow
    wr(3'd4, 32'h1);
    wr(3'd1, ONES - 32'd40); wait_pend();
    wr(3'd0, 32'h1);
    t0 = cyc;
    wait_irq(t1);
    check_rng("R1 overflow delay", t1 - t0, 100, 118);
    rd(3'd3, v); check("R1 status set", v, 1);
    repeat (30) @(posedge iclk);
    rd(3'd0, v); check("R2 start cleared", v, 0);
    rd(3'd1, v); check("R2 count zero", v, 0);

    // R6 and R7
    wr(3'd3, 32'h0);
    rd(3'd3, v); check("R6 write 0 keeps", v, 1);
    check("R7 irq on", {31'b0, irq}, 1);
    wr(3'd4, 32'h0); #1;
    check("R7 irq gated", {31'b0, irq}, 0);
    wr(3'd5, 32'h1); #1;
    check("R7 wake on", {31'b0, wake}, 1);
    wr(3'd5, 32'h0); wr(3'd4, 32'h1);
    wr(3'd3, 32'h1);
    rd(3'd3, v); check("R6 write 1 clears", v, 0);
    check("R6 irq low", {31'b0, irq}, 0);

    // R3 auto-reload period
    wr(3'd2, ONES - 32'd20);
    wr(3'd1, ONES - 32'd20); wait_pend();
    wr(3'd0, 32'h3);
    wait_irq(t0);
    wr(3'd3, 32'h1);
    wait_irq(t1);
    wr(3'd3, 32'h1);
    wait_irq(t2);
    check_rng("R3 reload period", t2 - t1, 48, 53);
    rd(3'd0, v); check("R3 still running", v, 3);

    // R9 stop holds count
    wr(3'd0, 32'h0); wait_pend(); repeat (20) @(posedge iclk);
    rd(3'd1, a); repeat (40) @(posedge iclk);
    rd(3'd1, v); check("R9 count held", v, a);
    check("R3 count in reload range", {31'b0, (a >= ONES - 32'd20)}, 1);
    wr(3'd3, 32'h1);

    // R5 non-posted
    wr(3'd6, 32'h0);
    xfer(1'b1, 3'd1, 32'h777, v, s);
    check_rng("R5 ready held", s, 5, 40);
    rd(3'd7, v); check("R5 pend reads 0", v, 0);
    repeat (30) @(posedge iclk);
    rd(3'd1, v); check("R5 count landed", v, 32'h777);

    // R10 soft reset
    wr(3'd4, 32'h1); wr(3'd2, 32'h99);
    wr(3'd6, 32'h5);
    for (int i = 0; i < 200; i++) begin
      rd(3'd6, v);
      if (!v[0]) break;
    end
    check("R10 bit self-clears", v, 0);
    rd(3'd2, v); check("R10 load", v, 0);
    rd(3'd4, v); check("R10 irq enable", v, 0);
    rd(3'd0, v); check("R10 ctrl", v, 0);
    repeat (30) @(posedge iclk);
    rd(3'd1, v); check("R10 count", v, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule